// File: doc/BRIEF.md
# Memory protection region checker

This block keeps a bank of twelve protection regions and decides, in the same cycle, whether a bus access may go ahead. Each region holds a start address, an end address, a set of access rights for each of eight bus masters, and a valid flag. Software loads the regions through a word-addressed register port. The bus side presents an address, a master number, an access kind (data read, data write or instruction fetch) and a privilege flag. It receives a hit flag, which is set when any valid region covers the address, and a permit flag.

The rights are not the same for every master. Masters 0 to 3 have a 5-bit field with user read/write/execute bits and a supervisor selector. Masters 4 to 7 have only a read enable and a write enable, so they can never fetch instructions. Any write to a region's end-address word invalidates that region. Software must then set it valid again, so a half-updated range is never used.

Top module: `mpu_region_check`

## Requirements
- R1: The register index is region*4+word. Word 0 holds the start address: bits 31:5 are stored and bits 4:0 read back as zero. Word 1 holds the end address. Word 2 holds the rights. Word 3 bit 0 holds the valid flag. Indices at or above 48 select no region and read as zero.
- R2: The effective end address has bits 4:0 forced to ones. Word 1 reads back with bits 4:0 as ones.
- R3: A write to word 1 of a region clears that region's valid flag from the next cycle on, whatever the data.
- R4: A write to word 3 loads the valid flag from data bit 0. Reset clears every valid flag.
- R5: A region matches an access when it is valid and start <= address <= effective end. A region whose end is below its start never matches. chk_hit is the OR of all matches.
- R6: For master m in 0..3, the rights field is word 2 bits [5m+4:5m]. Within the field, bit 2 is user read, bit 1 is user write and bit 0 is user execute. Bits 4:3 select the supervisor rights: 00 = same as user, 01 = read/write/execute, 10 = read/write only, 11 = read/execute only.
- R7: For master m in 4..7, the rights are word 2 bit 20+2(m-4) for read and bit 21+2(m-4) for write. Privilege has no effect, and fetches are always denied.
- R8: chk_kind is 0 for read, 1 for write and 2 for fetch. chk_permit is set when any matching region grants the requested kind to the master in its mode. It is clear when nothing matches, and it is clear for kind 3.
- R9: The check is combinational over the current region contents, so a register write takes effect on the check one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears valid flags |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 6 | Register index for writes (region*4+word) |
| wr_data | input | 32 | Register write data |
| rd_idx | input | 6 | Register index for reads |
| rd_data | output | 32 | Register read data (combinational) |
| chk_addr | input | 32 | Access address |
| chk_master | input | 3 | Requesting master number |
| chk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| chk_super | input | 1 | 1 for a supervisor-mode access |
| chk_hit | output | 1 | Some valid region covers the address |
| chk_permit | output | 1 | Access is allowed |

## Verification
A corrupted valid flag shows on chk_hit and chk_permit on the first check after the faulty write or reset. It also shows on word 3 read-back in that same cycle. A wrong rights decode shows only for the specific master, kind and mode it affects, so the vectors step through every supervisor selector and both master classes. Range errors show only at the edges, so the checks use addresses at the start, at the forced-ones end, one below the start, and inside an inverted range.

// File: rtl/mpu_region_check.sv
module mpu_region_check #(
  parameter int REGIONS = 12,
  parameter int AW      = 32,
  parameter int GRAN    = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [$clog2(REGIONS*4)-1:0]      wr_idx,
  input  logic [AW-1:0]                     wr_data,
  input  logic [$clog2(REGIONS*4)-1:0]      rd_idx,
  output logic [AW-1:0]                     rd_data,
  input  logic [AW-1:0]                     chk_addr,
  input  logic [2:0]                        chk_master,
  input  logic [1:0]                        chk_kind,
  input  logic                              chk_super,
  output logic                              chk_hit,
  output logic                              chk_permit
);
  localparam int IW = $clog2(REGIONS*4);
  localparam int TW = AW - GRAN;
  localparam int RW = 28;

  logic [TW-1:0]      start_q [REGIONS];
  logic [TW-1:0]      end_q   [REGIONS];
  logic [RW-1:0]      rights_q[REGIONS];
  logic [REGIONS-1:0] valid_q;
  logic [REGIONS-1:0] hit_v, grant_v;

  wire [IW-3:0] wr_reg = wr_idx[IW-1:2];
  wire [IW-3:0] rd_reg = rd_idx[IW-1:2];
  wire          wr_ok  = wr_en && (int'(wr_reg) < REGIONS);

  function automatic logic grants(input logic [RW-1:0] r, input logic [2:0] m,
                                  input logic [1:0] k, input logic s);
    logic [4:0] f;
    logic [2:0] rwx;
    logic [1:0] rw;
    grants = 1'b0;
    if (!m[2]) begin
      f   = r[int'(m)*5 +: 5];
      rwx = f[2:0];
      if (s) begin
        case (f[4:3])
          2'b01:   rwx = 3'b111;
          2'b10:   rwx = 3'b110;
          2'b11:   rwx = 3'b101;
          default: rwx = f[2:0];
        endcase
      end
      case (k)
        2'd0:    grants = rwx[2];
        2'd1:    grants = rwx[1];
        2'd2:    grants = rwx[0];
        default: grants = 1'b0;
      endcase
    end else begin
      rw = r[20 + int'(m[1:0])*2 +: 2];
      case (k)
        2'd0:    grants = rw[0];
        2'd1:    grants = rw[1];
        default: grants = 1'b0;
      endcase
    end
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      case (wr_idx[1:0])
        2'd0:    start_q[wr_reg]  <= wr_data[AW-1:GRAN];
        2'd1:    end_q[wr_reg]    <= wr_data[AW-1:GRAN];
        2'd2:    rights_q[wr_reg] <= wr_data[RW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_ok && wr_idx[1:0] == 2'd1) valid_q[wr_reg] <= 1'b0;
    else if (wr_ok && wr_idx[1:0] == 2'd3) valid_q[wr_reg] <= wr_data[0];
  end

  for (genvar g = 0; g < REGIONS; g++) begin : g_region
    assign hit_v[g] = valid_q[g]
                   && (chk_addr >= {start_q[g], {GRAN{1'b0}}})
                   && (chk_addr <= {end_q[g], {GRAN{1'b1}}});
    assign grant_v[g] = grants(rights_q[g], chk_master, chk_kind, chk_super);

    p_end_write_invalidates_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IW'(g*4+1)) |=> !valid_q[g]);
    p_valid_write_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IW'(g*4+3)) |=> (valid_q[g] == $past(wr_data[0])));
  end

  assign chk_hit    = |hit_v;
  assign chk_permit = |(hit_v & grant_v);

  always_comb begin
    rd_data = '0;
    if (int'(rd_reg) < REGIONS) begin
      case (rd_idx[1:0])
        2'd0:    rd_data = {start_q[rd_reg], {GRAN{1'b0}}};
        2'd1:    rd_data = {end_q[rd_reg], {GRAN{1'b1}}};
        2'd2:    rd_data = {{(AW-RW){1'b0}}, rights_q[rd_reg]};
        default: rd_data = {{(AW-1){1'b0}}, valid_q[rd_reg]};
      endcase
    end
  end

  p_permit_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_permit |-> chk_hit);
  p_upper_no_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_master[2] && chk_kind[1]) |-> !chk_permit);
  p_end_reads_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx[1:0] == 2'd1 && int'(rd_reg) < REGIONS) |-> (rd_data[GRAN-1:0] == {GRAN{1'b1}}));
  p_reserved_kind_denied_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_kind == 2'd3) |-> !chk_permit);
endmodule

// File: tb/mpu_region_check_test.sv
module mpu_region_check_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [31:0] chk_addr = '0;
  logic [2:0]  chk_master = '0;
  logic [1:0]  chk_kind = '0;
  logic        chk_super = 1'b0;
  logic        chk_hit, chk_permit;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  mpu_region_check uut (.*);

  // {addr, master, kind, super, hit, permit, req}
  localparam int NV = 24;
  localparam logic [47:0] VEC [NV] = '{
    {32'h0000_1000, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 8'd6},  // R6 user read
    {32'h0000_1000, 3'd0, 2'd1, 1'b0, 1'b1, 1'b0, 8'd6},  // R6 user no write
    {32'h0000_1000, 3'd0, 2'd1, 1'b1, 1'b1, 1'b1, 8'd6},  // R6 sup sel 01
    {32'h0000_1FFF, 3'd0, 2'd2, 1'b1, 1'b1, 1'b1, 8'd2},  // R2 forced-ones end
    {32'h0000_2000, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 inverted region
    {32'h0000_3000, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 8'd5},  // R5 inverted region
    {32'h0000_0FFF, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 below start
    {32'h0000_1800, 3'd0, 2'd1, 1'b0, 1'b1, 1'b1, 8'd8},  // R8 overlap OR
    {32'h0000_1800, 3'd0, 2'd2, 1'b0, 1'b1, 1'b0, 8'd8},  // R8 neither grants
    {32'h0000_1000, 3'd4, 2'd0, 1'b0, 1'b1, 1'b1, 8'd7},  // R7 read
    {32'h0000_1000, 3'd4, 2'd1, 1'b1, 1'b1, 1'b0, 8'd7},  // R7 write off
    {32'h0000_1000, 3'd4, 2'd2, 1'b1, 1'b1, 1'b0, 8'd7},  // R7 no fetch
    {32'h0000_8010, 3'd1, 2'd2, 1'b0, 1'b1, 1'b0, 8'd6},  // R6 user no x
    {32'h0000_8010, 3'd1, 2'd2, 1'b1, 1'b1, 1'b1, 8'd6},  // R6 sup sel 11
    {32'h0000_8010, 3'd1, 2'd1, 1'b1, 1'b1, 1'b0, 8'd6},  // R6 sel 11 no w
    {32'h0000_8010, 3'd1, 2'd1, 1'b0, 1'b1, 1'b1, 8'd6},  // R6 user write
    {32'h0000_8010, 3'd5, 2'd1, 1'b0, 1'b1, 1'b1, 8'd7},  // R7 write only
    {32'h0000_8010, 3'd5, 2'd0, 1'b1, 1'b1, 1'b0, 8'd7},  // R7 read off
    {32'h0000_80FF, 3'd2, 2'd0, 1'b1, 1'b1, 1'b0, 8'd8},  // R8 no rights
    {32'h0000_8100, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 past end
    {32'h0000_1800, 3'd2, 2'd2, 1'b0, 1'b1, 1'b1, 8'd6},  // R6 user x
    {32'h0000_1800, 3'd2, 2'd2, 1'b1, 1'b1, 1'b0, 8'd6},  // R6 sel 10 no x
    {32'h0000_1800, 3'd2, 2'd0, 1'b1, 1'b1, 1'b1, 8'd6},  // R6 sel 10 read
    {32'h0000_1800, 3'd0, 2'd3, 1'b1, 1'b1, 1'b0, 8'd8}   // R8 kind 3 denied
  };

  task automatic expect32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input string req, input logic [5:0] idx, input logic [31:0] exp);
    rd_idx = idx;
    #1;
    expect32(req, rd_data, exp);
  endtask

  task automatic chk(input string req, input logic [31:0] a, input logic [2:0] m,
                     input logic [1:0] k, input logic s, input logic h, input logic p);
    chk_addr = a; chk_master = m; chk_kind = k; chk_super = s;
    #1;
    expect32(req, {30'd0, chk_hit, chk_permit}, {30'd0, h, p});
  endtask

  initial begin
    #100us;
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd("R4", 6'd3, 32'd0);
    rd("R1", 6'd48, 32'd0);
    wr(6'd0, 32'h0000_1000); wr(6'd1, 32'h0000_1FE0); wr(6'd2, 32'h0010_000C);
    chk("R4", 32'h1000, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    wr(6'd3, 32'h1);
    chk("R9", 32'h1000, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1);
    wr(6'd4, 32'h0000_3000); wr(6'd5, 32'h0000_2000); wr(6'd6, 32'h0FFF_FFFF); wr(6'd7, 32'h1);
    wr(6'd8, 32'h0000_8000); wr(6'd9, 32'h0000_80FF); wr(6'd10, 32'h0080_03C0); wr(6'd11, 32'h1);
    wr(6'd12, 32'h0000_1800); wr(6'd13, 32'h0000_18FF); wr(6'd14, 32'h0000_4402); wr(6'd15, 32'h1);
    wr(6'd48, 32'hFFFF_FFFF);
    rd("R1", 6'd0, 32'h0000_1000);
    rd("R2", 6'd1, 32'h0000_1FFF);
    rd("R1", 6'd10, 32'h0080_03C0);
    rd("R1", 6'd48, 32'd0);
    for (int i = 0; i < NV; i++) begin
      chk($sformatf("R%0d vec%0d", VEC[i][7:0], i), VEC[i][47:16], VEC[i][15:13],
          VEC[i][12:11], VEC[i][10], VEC[i][9], VEC[i][8]);
    end
    rd("R3", 6'd3, 32'd1);
    wr(6'd1, 32'h0000_1FE0);
    rd("R3", 6'd3, 32'd0);
    chk("R3", 32'h1000, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    wr(6'd3, 32'h1);
    chk("R4", 32'h1000, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1);
    wr(6'd3, 32'h0);
    chk("R4", 32'h1000, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    rd("R4", 6'd3, 32'd0);
    chk("R8", 32'h1000, 3'd4, 2'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd("R4", 6'd11, 32'd0);
    chk("R4", 32'h8010, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule